// File: doc/BRIEF.md
# Serial Memory Read Slave

This block is the device end of a three-wire serial memory with 1 Kbit of storage. A host raises the select line, then clocks a frame into the data input on the serial clock: a start bit, a two-bit command and an address. If the command is a read, the block answers on its data output. It first drives a single zero, then sends the addressed word most significant bit first. After that it keeps sending the words at the following addresses on each serial clock, and it wraps from the last location back to location zero. This continues until the host drops the select line.

The organisation pin picks between 64 words of 16 bits and 128 bytes of 8 bits. The array is always stored as 64 sixteen-bit words. A back-door write port lets a test environment or a loader fill the array. All serial inputs are sampled in the system clock domain, and the block detects serial clock rises itself. Each high phase and each low phase of the serial clock must last at least one system clock. Any command other than a read is taken in and then ignored until the select line falls.

Top module: `mw_read_slave`

## Requirements
- R1: While idle, zeros on `din` are ignored. A frame begins at the first `din`=1 sampled on a rising `sk` with `cs` high.
- R2: After the start bit the frame carries a 2-bit command, then the address, both MSB first. Only command value binary 10 is a read.
- R3: `org`=1 selects 16-bit words with a 6-bit address. `org`=0 selects 8-bit bytes with a 7-bit address, where byte 2w is bits [15:8] of stored word w and byte 2w+1 is bits [7:0]. `org` is sampled only at the start bit; changing it later in the frame has no effect.
- R4: On the rising `sk` that carries the last address bit of a read, `dout_en` goes high and `dout` goes to 0. This is the leading dummy bit.
- R5: Each later rising `sk` drives the next data bit of the current word on `dout`, MSB first. There is no gap between words.
- R6: After the last bit of a word, the next rising `sk` drives the MSB of the next higher address. The address wraps from 63 to 0 (x16) or from 127 to 0 (x8).
- R7: When `cs` is low, `dout_en` is low one system clock later and any frame in progress is dropped. The next frame needs a new start bit.
- R8: A frame with a command other than 10 never raises `dout_en`, however many further `sk` rises arrive before `cs` falls.
- R9: While `sk` does not rise, `dout`, `dout_en` and the frame state hold. `din` changes in that time have no effect.
- R10: A back-door write (`bd_we`=1) stores `bd_data` at word `bd_addr`, and later reads return it.
- R11: Synchronous active-high `rst` leaves `dout_en`=0, `dout`=0 and the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select, high during a frame |
| sk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command and address input |
| org | input | 1 | Organisation: 1 = x16, 0 = x8 |
| dout | output | 1 | Serial read data |
| dout_en | output | 1 | Output enable for `dout` (high = driven) |
| bd_we | input | 1 | Back-door write strobe |
| bd_addr | input | 6 | Back-door word address |
| bd_data | input | 16 | Back-door write data |

## Verification
The bench aims at the word boundaries:
- It reads across the top of the array in both organisations. A pointer that fails to wrap, or wraps at the wrong width, streams stale or shifted data.
- It checks the dummy zero and the first data bit. This catches an off-by-one in address length, which shows up as a missing or doubled leading bit.
- It checks that byte order follows the high-then-low rule, which exposes swapped byte lanes.

It also covers the control paths:
- It drops the select line mid-address and mid-word, then holds the serial clock while toggling the input and flipping `org`. A design that keeps stale frame state, or re-reads `org`, misdecodes the next frame or corrupts the stream.
- It sends non-read commands, which must stay silent.

// File: rtl/mw_read_pkg.sv
package mw_read_pkg;
  localparam logic [1:0] CMD_READ = 2'b10;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_CMD,
    FR_ADDR,
    FR_STREAM,
    FR_DISCARD
  } frame_state_t;
endpackage

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/mw_frame_decoder.sv
module mw_frame_decoder
  import mw_read_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            sk,
  input  logic            din,
  input  logic            org,
  output logic            sk_rise,
  output logic            rd_start,
  output logic [ADDR_W:0] rd_addr,
  output logic            rd_x16
);
  localparam int CW = $clog2(ADDR_W + 1);
  localparam logic [CW-1:0] LAST_X16 = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] LAST_X8  = CW'(ADDR_W);

  frame_state_t      state;
  logic              sk_q;
  logic [1:0]        cmd;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] abuf;
  logic              org_l;
  logic              last_abit;

  assign sk_rise   = cs && sk && !sk_q;
  assign last_abit = (cnt == (org_l ? LAST_X16 : LAST_X8));
  assign rd_start  = sk_rise && (state == FR_ADDR) && last_abit && (cmd == CMD_READ);
  assign rd_addr   = {abuf, din};
  assign rd_x16    = org_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      sk_q  <= 1'b0;
      cmd   <= '0;
      cnt   <= '0;
      abuf  <= '0;
      org_l <= 1'b1;
    end else begin
      sk_q <= sk;
      if (!cs) begin
        state <= FR_IDLE;
      end else if (sk_rise) begin
        case (state)
          FR_IDLE: begin
            if (din) begin
              state <= FR_CMD;
              org_l <= org;
              cnt   <= '0;
              abuf  <= '0;
            end
          end
          FR_CMD: begin
            cmd <= {cmd[0], din};
            if (cnt == CW'(1)) begin
              state <= FR_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          FR_ADDR: begin
            abuf <= {abuf[ADDR_W-2:0], din};
            cnt  <= cnt + CW'(1);
            if (last_abit) state <= (cmd == CMD_READ) ? FR_STREAM : FR_DISCARD;
          end
          default: state <= state;
        endcase
      end
    end
  end

  // A frame can only be under way if select was high in the previous cycle
  assert_idle_after_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> (state == FR_IDLE));
endmodule

// File: rtl/mw_bit_streamer.sv
module mw_bit_streamer #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              rd_start,
  input  logic [ADDR_W:0]   rd_addr,
  input  logic              rd_x16,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] rd_word,
  output logic              dout,
  output logic              dout_en
);
  localparam int HB = DATA_W / 2;
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LEN_X16 = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LEN_X8  = BW'(HB - 1);
  localparam logic [ADDR_W-1:0] ONE_W = 1;
  localparam logic [ADDR_W:0]   ONE_B = 1;

  logic [ADDR_W:0]   ptr;
  logic [ADDR_W:0]   ptr_next;
  logic              x16_l;
  logic              active;
  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] fresh;

  assign rd_word  = x16_l ? ptr[ADDR_W-1:0] : ptr[ADDR_W:1];
  assign ptr_next = x16_l ? {1'b0, ptr[ADDR_W-1:0] + ONE_W} : ptr + ONE_B;

  always_comb begin
    if (x16_l)       fresh = rdata;
    else if (ptr[0]) fresh = {rdata[HB-1:0], {HB{1'b0}}};
    else             fresh = {rdata[DATA_W-1:HB], {HB{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      x16_l   <= 1'b1;
      active  <= 1'b0;
      sh      <= '0;
      bcnt    <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else if (!cs) begin
      active  <= 1'b0;
      dout_en <= 1'b0;
      dout    <= 1'b0;
    end else if (rd_start) begin
      ptr     <= rd_addr;
      x16_l   <= rd_x16;
      active  <= 1'b1;
      bcnt    <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b1;
    end else if (active && sk_rise) begin
      if (bcnt == '0) begin
        dout <= fresh[DATA_W-1];
        sh   <= fresh << 1;
        bcnt <= x16_l ? LEN_X16 : LEN_X8;
      end else begin
        dout <= sh[DATA_W-1];
        sh   <= sh << 1;
        bcnt <= bcnt - BW'(1);
        if (bcnt == BW'(1)) ptr <= ptr_next;
      end
    end
  end

  assert_disable_when_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !dout_en);

  assert_dummy_zero_first_R4: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> (dout_en && !dout));

  assert_hold_without_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (cs && !sk_rise && !rd_start) |=> ($stable(dout) && $stable(dout_en)));
endmodule

// File: rtl/mw_read_slave.sv
module mw_read_slave #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sk,
  input  logic              din,
  input  logic              org,
  output logic              dout,
  output logic              dout_en,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [DATA_W-1:0] bd_data
);
  logic              sk_rise;
  logic              rd_start;
  logic [ADDR_W:0]   rd_addr;
  logic              rd_x16;
  logic [ADDR_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata;

  mw_frame_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .sk       (sk),
    .din      (din),
    .org      (org),
    .sk_rise  (sk_rise),
    .rd_start (rd_start),
    .rd_addr  (rd_addr),
    .rd_x16   (rd_x16)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .wr_en   (bd_we),
    .wr_addr (bd_addr),
    .wr_data (bd_data),
    .rd_addr (rd_word),
    .rd_data (rdata)
  );

  mw_bit_streamer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_str (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .sk_rise  (sk_rise),
    .rd_start (rd_start),
    .rd_addr  (rd_addr),
    .rd_x16   (rd_x16),
    .rdata    (rdata),
    .rd_word  (rd_word),
    .dout     (dout),
    .dout_en  (dout_en)
  );
endmodule

// File: tb/mw_read_slave_tb_top.sv
module mw_read_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, din = 1'b0, org = 1'b1;
  logic bd_we = 1'b0;
  logic [5:0] bd_addr = '0;
  logic [15:0] bd_data = '0;
  logic dout, dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] model [64];
  logic [2:0] exp_q [$];
  string rq_q [$];

  always #4 clk = ~clk;

  mw_read_slave dut_i (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .din(din), .org(org),
    .dout(dout), .dout_en(dout_en),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic exp_bit(input bit x16, input int a, input int k);
    int ww = x16 ? 16 : 8;
    int depth = x16 ? 64 : 128;
    int idx = (a + k / ww) % depth;
    int b = ww - 1 - (k % ww);
    logic [15:0] w;
    if (x16) return model[idx][b];
    w = model[idx / 2];
    return (idx % 2 == 0) ? w[8 + b] : w[b];
  endfunction

  // Monitor: pops one expected item per rising sk and compares mid-phase
  initial forever begin
    logic [2:0] it;
    string r;
    @(posedge sk);
    repeat (3) @(negedge clk);
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      r = rq_q.pop_front();
      check(dout_en == it[2], r, {31'd0, dout_en}, {31'd0, it[2]});
      if (it[1]) check(dout == it[0], r, {31'd0, dout}, {31'd0, it[0]});
    end
  end

  // Driver: push expectation (en, compare value, value), then clock one bit
  task automatic sk_bit(input logic d, input logic ee, input logic ck, input logic ev, input string rq);
    exp_q.push_back({ee, ck, ev});
    rq_q.push_back(rq);
    @(negedge clk) din = d;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk) cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_head(input bit x16, input logic [1:0] cmd, input int a, input int zeros, input bit is_read, input string rq);
    int aw = x16 ? 6 : 7;
    @(negedge clk) begin cs = 1'b1; org = x16; end
    repeat (2) @(negedge clk);
    for (int i = 0; i < zeros; i++) sk_bit(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    sk_bit(1'b1, 1'b0, 1'b0, 1'b0, rq);
    sk_bit(cmd[1], 1'b0, 1'b0, 1'b0, rq);
    sk_bit(cmd[0], 1'b0, 1'b0, 1'b0, rq);
    for (int i = aw - 1; i > 0; i--) sk_bit(a[i], 1'b0, 1'b0, 1'b0, rq);
    if (is_read) sk_bit(a[0], 1'b1, 1'b1, 1'b0, "R4");
    else         sk_bit(a[0], 1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic do_read(input bit x16, input int a, input int nbits, input int hold_at, input string rq);
    send_head(x16, 2'b10, a, 0, 1'b1, rq);
    for (int k = 0; k < nbits; k++) begin
      sk_bit(1'b0, 1'b1, 1'b1, exp_bit(x16, a, k), rq);
      if (k == hold_at) begin
        logic hd = dout;
        logic he = dout_en;
        for (int j = 0; j < 10; j++) begin
          @(negedge clk) begin din = ~din; org = ~org; end
          repeat (4) @(negedge clk);
          check(dout == hd && dout_en == he, "R9", {30'd0, dout_en, dout}, {30'd0, he, hd});
        end
      end
    end
    deselect();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dout_en == 1'b0, "R11", {31'd0, dout_en}, 32'd0);
    check(dout == 1'b0, "R11", {31'd0, dout}, 32'd0);

    // R10: preload through the back door
    for (int i = 0; i < 64; i++) begin
      model[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
      @(negedge clk) begin bd_we = 1'b1; bd_addr = 6'(i); bd_data = model[i]; end
    end
    @(negedge clk) bd_we = 1'b0;

    // R1, R2, R5: x16 read with leading zeros, three words
    send_head(1'b1, 2'b10, 5, 3, 1'b1, "R2");
    for (int k = 0; k < 48; k++) sk_bit(1'b0, 1'b1, 1'b1, exp_bit(1'b1, 5, k), "R5");
    deselect();

    // R6: x16 wrap 63 -> 0
    do_read(1'b1, 63, 32, -1, "R6");
    // R3, R6: x8 wrap 127 -> 0, then byte lanes at 10
    do_read(1'b0, 127, 24, -1, "R6");
    do_read(1'b0, 10, 24, -1, "R3");

    // R8: non-read commands stay silent
    send_head(1'b1, 2'b11, 9, 0, 1'b0, "R8");
    for (int k = 0; k < 20; k++) sk_bit(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    deselect();
    send_head(1'b0, 2'b01, 33, 1, 1'b0, "R8");
    for (int k = 0; k < 12; k++) sk_bit(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    deselect();

    // R7: abort mid-address, then mid-word
    @(negedge clk) begin cs = 1'b1; org = 1'b1; end
    repeat (2) @(negedge clk);
    sk_bit(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    sk_bit(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    sk_bit(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    sk_bit(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    deselect();
    send_head(1'b1, 2'b10, 20, 0, 1'b1, "R7");
    for (int k = 0; k < 6; k++) sk_bit(1'b0, 1'b1, 1'b1, exp_bit(1'b1, 20, k), "R7");
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
    check(dout_en == 1'b0, "R7", {31'd0, dout_en}, 32'd0);
    repeat (2) @(negedge clk);
    do_read(1'b1, 40, 16, -1, "R7");

    // R9 and R3: hold sk while toggling din and org mid-stream
    do_read(1'b0, 77, 20, 5, "R9");
    do_read(1'b1, 30, 24, 9, "R3");

    // R10: overwrite one word and read it back
    model[7] = 16'h8001;
    @(negedge clk) begin bd_we = 1'b1; bd_addr = 6'd7; bd_data = 16'h8001; end
    @(negedge clk) bd_we = 1'b0;
    do_read(1'b1, 7, 16, -1, "R10");
    do_read(1'b0, 15, 8, -1, "R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule